// File: doc/BRIEF.md
# Single-Clock FIFO with Replay and Half-Full Status

This block is a first-in/first-out buffer that runs on one clock. Words of `WIDTH` bits (9 by default) are written into a memory of `DEPTH` locations (16 by default) and read back in the order they arrived. Requests are one-cycle strobes that are sampled on the rising clock edge. A read returns its word on the cycle after the request, together with a one-cycle valid pulse. When no read is returned, the data output holds zero.

Three active-low status flags report the buffer state: empty, full and more-than-half-full. Writes into a full buffer are dropped, and reads from an empty buffer are dropped. A replay strobe moves the read pointer back to the first memory location and leaves the write pointer where it is. A block of data written once after reset can therefore be read out again as often as needed, provided fewer than `DEPTH` words have been written since that reset.

Top module: `fifo_rt_hf`

## Requirements
- R1: Reset is synchronous on `rst_n` = 0. After the reset edge, both pointers are at location 0 and stored words are discarded. The outputs are `empty_n`=0, `full_n`=1, `half_n`=1 and `rd_valid`=0.
- R2: A write strobe while `full_n`=1 stores `wr_data` at the next consecutive location. Accepted words are read out in the order they were written.
- R3: `empty_n` is 0 exactly when the occupancy is zero. A read strobe while empty is ignored: `rd_valid` stays 0 and the read pointer does not move.
- R4: With no reads after reset, `full_n` goes to 0 on the edge of the DEPTH-th write and not before. Write strobes while full are ignored. `full_n` returns to 1 on the edge of the next accepted read.
- R5: `half_n` goes to 0 on the write edge that makes the occupancy greater than DEPTH/2. It returns to 1 on the read edge that brings the occupancy back to DEPTH/2 or less.
- R6: A replay strobe `rt_req` with `wr_en`=0 and `rd_en`=0 sets the read pointer to location 0 and leaves the write pointer unchanged. The occupancy becomes the index of the write pointer, and the flags follow on the same edge.
- R7: A replay strobe in the same cycle as a read or write strobe is ignored, and that read or write proceeds normally.
- R8: After one accepted write into an empty buffer, `empty_n` is 1 on that same edge, and a read in the next cycle succeeds.
- R9: If read and write strobes arrive together, only the write takes effect when the buffer is empty, only the read takes effect when it is full, and both take effect otherwise.
- R10: `rd_valid` is 1 for exactly the one cycle after an accepted read, with that word on `rd_data`. `rd_data` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe |
| rt_req | input | 1 | Replay strobe: rewind the read pointer |
| rd_data | output | WIDTH | Word returned by a read, zero otherwise |
| rd_valid | output | 1 | High for one cycle with returned data |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when all DEPTH locations hold words |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
The properties assume that all inputs are settled at each rising edge and that `rst_n` is held low for at least one edge before any strobe arrives. The replay checks also assume that fewer than DEPTH words have been written since the last reset, because only then is the occupancy after a replay meaningful. The bench changes its inputs only on falling edges. Every replay sequence starts from a fresh reset and writes five words before it rewinds.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RD,
    OP_WR,
    OP_RW,
    OP_RT
  } fifo_op_e;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= ram[raddr];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rt_req,
  output logic          wr_do,
  output logic          rd_do,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] count, count_nx;
  fifo_op_e      op;

  assign rd_do = rd_en && (count != '0);
  assign wr_do = wr_en && (count != FULL_CNT);

  always_comb begin
    if (rt_req && !wr_en && !rd_en) op = OP_RT;
    else begin
      unique case ({wr_do, rd_do})
        2'b11:   op = OP_RW;
        2'b10:   op = OP_WR;
        2'b01:   op = OP_RD;
        default: op = OP_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      OP_WR:   count_nx = count + 1'b1;
      OP_RD:   count_nx = count - 1'b1;
      OP_RT:   count_nx = {1'b0, wr_ptr};
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      if (wr_do) wr_ptr <= wr_ptr + 1'b1;
      if (op == OP_RT) rd_ptr <= '0;
      else if (rd_do) rd_ptr <= rd_ptr + 1'b1;
      count   <= count_nx;
      empty_n <= (count_nx != '0);
      full_n  <= (count_nx != FULL_CNT);
      half_n  <= !(count_nx > HALF_CNT);
    end
  end
endmodule

// File: rtl/fifo_rt_hf.sv
module fifo_rt_hf #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rt_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_do, rd_do;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] ram_q;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rt_req  (rt_req),
    .wr_do   (wr_do),
    .rd_do   (rd_do),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_do),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (rd_do),
    .raddr (rd_ptr),
    .q     (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_do;
  end

  assign rd_data = rd_valid ? ram_q : '0;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rt_req,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic             empty_n,
  input logic             full_n,
  input logic             half_n
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!empty_n && full_n && half_n && !rd_valid));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> !rd_valid);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en && !rd_en) |=> !full_n);

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n || full_n));

  a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);

  a_r7_read_beats_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rt_req && empty_n) |=> rd_valid);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

bind fifo_rt_hf fifo_rt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rt_req   (rt_req),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .empty_n  (empty_n),
  .full_n   (full_n),
  .half_n   (half_n)
);

// File: tb/tb_fifo_rt_hf.sv
module tb_fifo_rt_hf;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, empty_n, full_n, half_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_rt_hf #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rt_req(rt_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  // Vector fields: [24] wr, [23] rd, [22] rt, [21:13] din,
  // [12] expected valid, [11:3] expected data, [2:0] expected {empty_n, full_n, half_n}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 9'h101, 1'b0, 9'h000, 3'b111}, // R8 R2 first write
    {1'b1, 1'b0, 1'b0, 9'h0A2, 1'b0, 9'h000, 3'b111}, // R2
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h101, 3'b111}, // R2 R10 order
    {1'b1, 1'b1, 1'b0, 9'h033, 1'b1, 9'h0A2, 3'b111}, // R9 both act
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h033, 3'b011}, // R3 goes empty
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 9'h000, 3'b011}, // R3 read ignored
    {1'b1, 1'b1, 1'b0, 9'h1FF, 1'b0, 9'h000, 3'b111}, // R9 empty: write only
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h1FF, 3'b011}  // R9 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [W-1:0] d, input logic r, input logic t);
    wr_en = w; wr_data = d; rd_en = r; rt_req = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; rt_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_flags(input string req, input logic [2:0] exp);
    check(req, {29'd0, empty_n, full_n, half_n}, {29'd0, exp});
  endtask

  task automatic check_rd(input string req, input logic v, input logic [W-1:0] d);
    check(req, {22'd0, rd_valid, rd_data}, {22'd0, v, d});
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 37 + 5) % 512);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    check_flags("R1 reset flags", 3'b011);
    check_rd("R1 reset valid", 1'b0, '0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][24], VEC[k][21:13], VEC[k][23], VEC[k][22]);
      check_rd($sformatf("R10 vector %0d data", k), VEC[k][12], VEC[k][11:3]);
      check_flags($sformatf("R3 R4 R5 vector %0d flags", k), VEC[k][2:0]);
    end

    // R1: reset discards stored words
    step(1'b1, 9'h011, 1'b0, 1'b0);
    step(1'b1, 9'h022, 1'b0, 1'b0);
    do_reset();
    check_flags("R1 reset after writes", 3'b011);
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R1 nothing readable after reset", 1'b0, '0);

    // Fill: R4 R5
    for (int i = 0; i < D; i++) begin
      step(1'b1, pat(i), 1'b0, 1'b0);
      if (i == D/2 - 1) check_flags("R5 half not yet at DEPTH/2", 3'b111);
      if (i == D/2)     check_flags("R5 half set above DEPTH/2", 3'b110);
      if (i == D - 2)   check_flags("R4 full not yet", 3'b110);
      if (i == D - 1)   check_flags("R4 full after DEPTH writes", 3'b100);
    end
    step(1'b1, 9'h155, 1'b0, 1'b0);
    check_flags("R4 write while full ignored", 3'b100);
    check_rd("R4 no read data", 1'b0, '0);
    step(1'b1, 9'h0EE, 1'b1, 1'b0);
    check_rd("R9 full: read only", 1'b1, pat(0));
    check_flags("R4 full clears after read", 3'b110);
    for (int k = 1; k < D; k++) begin
      step(1'b0, '0, 1'b1, 1'b0);
      check_rd($sformatf("R2 order item %0d", k), 1'b1, pat(k));
      if (k == 6) check_flags("R5 half held at DEPTH/2+1", 3'b110);
      if (k == 7) check_flags("R5 half clears at DEPTH/2", 3'b111);
    end
    check_flags("R4 R9 dropped writes never stored", 3'b011);

    // Replay: R6 R7
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, pat(20 + i), 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R2 before replay", 1'b1, pat(21));
    step(1'b0, '0, 1'b0, 1'b1);
    check_rd("R6 replay returns no data", 1'b0, '0);
    check_flags("R6 flags after replay", 3'b111);
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R6 replay restarts at first word", 1'b1, pat(20));
    step(1'b1, 9'h0C3, 1'b0, 1'b1);
    check_rd("R7 replay with write: no read", 1'b0, '0);
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R7 replay with write ignored", 1'b1, pat(21));
    step(1'b0, '0, 1'b1, 1'b1);
    check_rd("R7 replay with read: read proceeds", 1'b1, pat(22));
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R7 replay with read ignored", 1'b1, pat(23));
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R6 write pointer kept", 1'b1, pat(24));
    step(1'b0, '0, 1'b1, 1'b0);
    check_rd("R7 write beside replay stored", 1'b1, 9'h0C3);
    check_flags("R6 occupancy from write pointer", 3'b011);
    step(1'b0, '0, 1'b0, 1'b0);
    check_rd("R10 valid lasts one cycle", 1'b0, '0);

    finish_run();
  end
endmodule